// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a clocked requester and an external asynchronous static RAM with a 16-bit data bus and two byte lanes. The requester presents one request at a time: an address, write data, a per-lane byte mask and a write flag, qualified by a valid strobe. The sequencer turns each request into a correctly timed sequence on the memory pins. These pins are chip select, output strobe, write strobe, the two lane enables, the address and the write data with its drive enable.

Every phase of a memory cycle lasts a whole number of clock cycles. Each count is derived at elaboration from a clock-period parameter and the memory's timing limits in picoseconds. The phases are read access, write address setup, write pulse, write recovery and bus release after a read. Read data comes back on a one-cycle response strobe. Lanes that were not requested return zero. A request with an empty mask finishes at once and never touches the memory pins.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, req_ready is 1. mem_ce_n, mem_oe_n and mem_we_n are 1, mem_be_n is 2'b11, and mem_dq_oe and rsp_valid are 0.
- R2: A read with a non-zero mask holds mem_ce_n and mem_oe_n low and mem_we_n high for exactly RD cycles, where RD = ceil(T_ACCESS_PS / CLK_PERIOD_PS). It samples mem_dq_in on the last of those cycles. It then pulses rsp_valid high for one cycle. Every accepted read gets exactly one response.
- R3: Mask bit 0 selects the lower lane, data bits 7:0, and drives mem_be_n[0] low. Mask bit 1 selects the upper lane, data bits 15:8, and drives mem_be_n[1] low. A write changes only the selected lanes. Read data on unselected lanes is returned as zero. Both lane enables are high whenever mem_ce_n is high.
- R4: A write with a non-zero mask keeps mem_ce_n low and drives the write data for its whole duration. mem_we_n stays high for SU setup cycles, then low for PW pulse cycles, then high again for RC recovery cycles before chip select is released. Address and data do not change from the pulse until the release.
- R5: mem_dq_oe is high only while mem_ce_n is low and mem_oe_n is high. mem_oe_n stays high throughout every write.
- R6: A write whose previous memory operation was a read first waits TA = ceil(T_BUS_RELEASE_PS / CLK_PERIOD_PS) cycles with chip select high and the bus undriven. With back-to-back requests this makes the chip-select-high gap TA+1 cycles. Write after write, read after read and read after write start on the cycle after acceptance, which gives a gap of 1.
- R7: A request with mask 2'b00 is consumed in the cycle it is offered. req_ready stays high, chip select never falls and memory is unchanged. For a read, rsp_valid pulses on the next cycle with data zero.
- R8: req_ready drops on the cycle after a non-zero-mask request is accepted and returns high on the cycle the operation completes. A request offered while req_ready is low has no effect.
- R9: Each phase count is ceil(time / CLK_PERIOD_PS) with a floor of one cycle. PW covers the larger of the write-pulse and data-setup limits. RC is stretched so that SU+PW+RC covers the write cycle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (17) | Word address |
| req_wdata | input | DW (16) | Write data |
| req_mask | input | DW/8 (2) | Byte lane select, bit 0 lower lane |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DW (16) | Read data, unselected lanes zero |
| mem_addr | output | AW (17) | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | DW/8 (2) | Lane enables, active low |
| mem_dq_out | output | DW (16) | Data driven toward memory |
| mem_dq_oe | output | 1 | Data driver enable for the pad |
| mem_dq_in | input | DW (16) | Data read from the pad |

## Verification
A phase counter that loads the wrong count shows up within one operation as a strobe of the wrong width, measured at the pins against the computed cycle counts. A stale previous-operation flag shows up as a chip-select gap that is too short or too long on the very next write. A sequencer that leaves its state early or late shows up as a read sample taken before the model drives the lanes, or as a response that arrives with the wrong data or none at all. A single wrong cycle of lane decode corrupts the neighbouring byte, which the scoreboard sees on the next read of that word.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURN
    } ctl_state_e;

    // Whole clock cycles covering a time limit, never less than one.
    function automatic int unsigned wait_cycles(input int unsigned t_ps,
                                                input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        if (n < 1) n = 1;
        return n;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
    parameter int unsigned LANES = 2
) (
    input  logic [LANES-1:0]   lane_en,
    input  logic [8*LANES-1:0] raw,
    output logic [8*LANES-1:0] gated
);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign gated[gi*8 +: 8] = lane_en[gi] ? raw[gi*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned AW               = 17,
    parameter int unsigned DW               = 16,
    parameter int unsigned CLK_PERIOD_PS    = 8000,
    parameter int unsigned T_ACCESS_PS      = 10000,
    parameter int unsigned T_WCYCLE_PS      = 10000,
    parameter int unsigned T_ADDR_SETUP_PS  = 0,
    parameter int unsigned T_WE_PULSE_PS    = 7000,
    parameter int unsigned T_DATA_SETUP_PS  = 5000,
    parameter int unsigned T_WR_HOLD_PS     = 0,
    parameter int unsigned T_BUS_RELEASE_PS = 5000,
    localparam int unsigned LANES           = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_mask,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_ce_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [LANES-1:0] mem_be_n,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe,
    input  logic [DW-1:0]    mem_dq_in
);

    // Phase lengths in clock cycles
    localparam int unsigned RD_W  = wait_cycles(T_ACCESS_PS, CLK_PERIOD_PS);
    localparam int unsigned SU_W  = wait_cycles(T_ADDR_SETUP_PS, CLK_PERIOD_PS);
    localparam int unsigned PW_W  = max2(wait_cycles(T_WE_PULSE_PS, CLK_PERIOD_PS),
                                         wait_cycles(T_DATA_SETUP_PS, CLK_PERIOD_PS));
    localparam int unsigned WC_W  = wait_cycles(T_WCYCLE_PS, CLK_PERIOD_PS);
    localparam int unsigned RC_W  = max2(wait_cycles(T_WR_HOLD_PS, CLK_PERIOD_PS),
                                         (WC_W > SU_W + PW_W) ? (WC_W - SU_W - PW_W) : 1);
    localparam int unsigned TA_W  = wait_cycles(T_BUS_RELEASE_PS, CLK_PERIOD_PS);
    localparam int unsigned MAX_W = max2(max2(RD_W, SU_W), max2(max2(PW_W, RC_W), TA_W));
    localparam int unsigned CW    = (MAX_W < 2) ? 1 : $clog2(MAX_W);

    localparam logic [CW-1:0] RD_L = CW'(RD_W - 1);
    localparam logic [CW-1:0] SU_L = CW'(SU_W - 1);
    localparam logic [CW-1:0] PW_L = CW'(PW_W - 1);
    localparam logic [CW-1:0] RC_L = CW'(RC_W - 1);
    localparam logic [CW-1:0] TA_L = CW'(TA_W - 1);

    typedef struct packed {
        ctl_state_e       st;
        logic             ready;
        logic             rsp_valid;
        logic [DW-1:0]    rdata;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [LANES-1:0] lanes;
        logic             ce_n;
        logic             oe_n;
        logic             we_n;
        logic [LANES-1:0] be_n;
        logic             dq_oe;
        logic             after_read;
    } regs_t;

    regs_t            q, d;
    logic             tmr_load;
    logic [CW-1:0]    tmr_val;
    logic             tmr_expired;
    logic [DW-1:0]    rd_gated;

    sram_wait_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_lane_gate #(.LANES(LANES)) u_rd_gate (
        .lane_en (~q.be_n),
        .raw     (mem_dq_in),
        .gated   (rd_gated)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && q.ready) begin
                    if (req_mask == '0) begin
                        // empty mask: consumed with no memory access
                        if (!req_write) begin
                            d.rsp_valid = 1'b1;
                            d.rdata     = '0;
                        end
                    end else begin
                        d.addr  = req_addr;
                        d.lanes = req_mask;
                        d.wdata = req_wdata;
                        d.ready = 1'b0;
                        if (!req_write) begin
                            d.st         = ST_RD_ACCESS;
                            d.ce_n       = 1'b0;
                            d.oe_n       = 1'b0;
                            d.be_n       = ~req_mask;
                            d.after_read = 1'b1;
                            tmr_load     = 1'b1;
                            tmr_val      = RD_L;
                        end else if (q.after_read) begin
                            d.st         = ST_TURN;
                            d.after_read = 1'b0;
                            tmr_load     = 1'b1;
                            tmr_val      = TA_L;
                        end else begin
                            d.st     = ST_WR_SETUP;
                            d.ce_n   = 1'b0;
                            d.be_n   = ~req_mask;
                            d.dq_oe  = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = SU_L;
                        end
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    d.rdata     = rd_gated;
                    d.rsp_valid = 1'b1;
                    d.ce_n      = 1'b1;
                    d.oe_n      = 1'b1;
                    d.be_n      = '1;
                    d.ready     = 1'b1;
                    d.st        = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (tmr_expired) begin
                    d.st     = ST_WR_SETUP;
                    d.ce_n   = 1'b0;
                    d.be_n   = ~q.lanes;
                    d.dq_oe  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = SU_L;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    d.st     = ST_WR_PULSE;
                    d.we_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = PW_L;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    d.st     = ST_WR_RECOVER;
                    d.we_n   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = RC_L;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_expired) begin
                    d.st    = ST_IDLE;
                    d.ce_n  = 1'b1;
                    d.be_n  = '1;
                    d.dq_oe = 1'b0;
                    d.ready = 1'b1;
                end
            end
            default: begin
                d.st    = ST_IDLE;
                d.ce_n  = 1'b1;
                d.oe_n  = 1'b1;
                d.we_n  = 1'b1;
                d.be_n  = '1;
                d.dq_oe = 1'b0;
                d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st         <= ST_IDLE;
            q.ready      <= 1'b1;
            q.rsp_valid  <= 1'b0;
            q.rdata      <= '0;
            q.addr       <= '0;
            q.wdata      <= '0;
            q.lanes      <= '0;
            q.ce_n       <= 1'b1;
            q.oe_n       <= 1'b1;
            q.we_n       <= 1'b1;
            q.be_n       <= '1;
            q.dq_oe      <= 1'b0;
            q.after_read <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = q.ready;
    assign rsp_valid  = q.rsp_valid;
    assign rsp_rdata  = q.rdata;
    assign mem_addr   = q.addr;
    assign mem_ce_n   = q.ce_n;
    assign mem_oe_n   = q.oe_n;
    assign mem_we_n   = q.we_n;
    assign mem_be_n   = q.be_n;
    assign mem_dq_out = q.wdata;
    assign mem_dq_oe  = q.dq_oe;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int unsigned AW    = 17,
    parameter int unsigned DW    = 16,
    parameter int unsigned LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LANES-1:0] req_mask,
    input logic             rsp_valid,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_ce_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic [LANES-1:0] mem_be_n,
    input logic [DW-1:0]    mem_dq_out,
    input logic             mem_dq_oe
);

    // R1: quiet pins in the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && mem_ce_n && mem_oe_n && mem_we_n &&
                          !mem_dq_oe && !rsp_valid));

    // R2: the output strobe only appears inside a selected, non-write cycle
    a_r2_read_strobe_framed: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && (mem_be_n != '1)));

    // R3: lane enables idle whenever the chip is not selected
    a_r3_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_be_n == '1));

    // R4: the write pulse sits inside chip select with data driven
    a_r4_pulse_framed: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

    // R4: address and data held, chip still selected, one cycle after pulse cycles
    a_r4_hold_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out) && !mem_ce_n));

    // R5: no drive while the memory may drive
    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    // R6: at least one cycle of release after the output strobe
    a_r6_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> !mem_dq_oe);

    // R7: empty-mask request leaves pins idle and ready high
    a_r7_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask == '0)) |=> (req_ready && mem_ce_n));

    // R8: a response always coincides with ready
    a_r8_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .AW    (AW),
    .DW    (DW),
    .LANES (LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_mask   (req_mask),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_be_n   (mem_be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;

    function automatic int ws(input int t, input int p);
        int n;
        n = (t + p - 1) / p;
        return (n < 1) ? 1 : n;
    endfunction

    localparam int CLK_PS = 8000;
    localparam int RD_W   = ws(10000, CLK_PS);
    localparam int SU_W   = ws(0, CLK_PS);
    localparam int PW_W   = (ws(7000, CLK_PS) > ws(5000, CLK_PS)) ? ws(7000, CLK_PS) : ws(5000, CLK_PS);
    localparam int WC_W   = ws(10000, CLK_PS);
    localparam int RC_RAW = (WC_W > SU_W + PW_W) ? (WC_W - SU_W - PW_W) : 1;
    localparam int RC_W   = (ws(0, CLK_PS) > RC_RAW) ? ws(0, CLK_PS) : RC_RAW;
    localparam int TA_W   = ws(5000, CLK_PS);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_ready, req_write;
    logic [16:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_mask;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out, mem_dq_in;

    always #4 clk = ~clk;

    sram_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory model
    logic [15:0] ram    [0:255];
    logic [15:0] shadow [0:255];

    always_comb begin
        mem_dq_in[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[0]) ?
                          ram[mem_addr[7:0]][7:0] : 8'h5A;
        mem_dq_in[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[1]) ?
                          ram[mem_addr[7:0]][15:8] : 8'h5A;
    end

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) begin
            if (!mem_be_n[0]) ram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_be_n[1]) ram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lm(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    // scoreboard
    logic [15:0] exp_q [$];
    logic [15:0] e;
    logic [1:0]  exp_be = 2'b11;

    task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] dat,
                         input logic [1:0] m);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = dat;
        req_mask  = m;
        exp_be    = ~m;
        if (wr) shadow[a[7:0]] = (shadow[a[7:0]] & ~lm(m)) | (dat & lm(m));
        else    exp_q.push_back(shadow[a[7:0]] & lm(m));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // pin monitor
    int  oe_lo = 0, ce_hi = 0, su = 0, rc = 0, we_lo = 0, last_gap = 0, bus_ops = 0;
    bit  seen_we = 0, wr_oe_low = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) wr_oe_low = 1;
            if (!mem_oe_n) oe_lo++;
            else if (oe_lo != 0) begin
                chk(oe_lo == RD_W, "R2", "read strobe cycles", oe_lo, RD_W);
                oe_lo = 0;
            end
            if (!mem_ce_n) begin
                if (ce_hi != 0) begin
                    last_gap = ce_hi;
                    ce_hi = 0;
                    bus_ops++;
                    chk(mem_be_n == exp_be, "R3", "lane enables", mem_be_n, exp_be);
                end
                if (mem_dq_oe) begin
                    if (!mem_we_n) begin we_lo++; seen_we = 1; end
                    else if (!seen_we) su++;
                    else rc++;
                end
            end else begin
                ce_hi++;
                if (seen_we) begin
                    chk(su == SU_W, "R4", "setup cycles", su, SU_W);
                    chk(we_lo == PW_W, "R9", "pulse cycles", we_lo, PW_W);
                    chk(rc == RC_W, "R4", "recovery cycles", rc, RC_W);
                    chk(!wr_oe_low, "R5", "drive during output strobe", wr_oe_low, 0);
                end
                su = 0; rc = 0; we_lo = 0; seen_we = 0; wr_oe_low = 0;
            end
            if (rsp_valid) begin
                if (exp_q.size() == 0) chk(0, "R8", "unexpected response", rsp_rdata, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R2", "read data", rsp_rdata, e);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin ram[i] = '0; shadow[i] = '0; end
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
        fork
            begin
                repeat (4) @(negedge clk);
                // R1 reset state
                chk(req_ready == 1, "R1", "ready in reset", req_ready, 1);
                chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1", "strobes in reset",
                    {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
                chk(mem_be_n == 2'b11, "R1", "lanes in reset", mem_be_n, 2'b11);
                chk(!mem_dq_oe && !rsp_valid, "R1", "drive/resp in reset",
                    {mem_dq_oe, rsp_valid}, 0);
                rst_n = 1'b1;
                @(negedge clk);
                chk(req_ready == 1 && mem_ce_n == 1, "R1", "idle after release",
                    {req_ready, mem_ce_n}, 2'b11);

                // writes back to back: no release gap (R6)
                issue(1, 17'h00010, 16'hA5C3, 2'b11);
                issue(1, 17'h00011, 16'h1234, 2'b11);
                wait_done();
                chk(last_gap == 1, "R6", "write after write gap", last_gap, 1);

                // read then write: release gap (R6)
                issue(0, 17'h00010, 16'h0, 2'b11);
                issue(1, 17'h00010, 16'h1111, 2'b01);
                wait_done();
                chk(last_gap == TA_W + 1, "R6", "write after read gap", last_gap, TA_W + 1);

                // upper-lane write, lane-selective reads (R3)
                issue(1, 17'h00010, 16'h2222, 2'b10);
                issue(0, 17'h00010, 16'h0, 2'b11);
                issue(0, 17'h00010, 16'h0, 2'b01);
                issue(0, 17'h00010, 16'h0, 2'b10);
                wait_done();
                chk(last_gap == 1, "R6", "read after read gap", last_gap, 1);

                // R7 empty mask
                begin
                    int ops0;
                    ops0 = bus_ops;
                    issue(1, 17'h00011, 16'hFFFF, 2'b00);
                    chk(req_ready == 1, "R7", "ready after empty write", req_ready, 1);
                    issue(0, 17'h00011, 16'h0, 2'b00);
                    wait_done();
                    chk(bus_ops == ops0, "R7", "no chip select", bus_ops, ops0);
                    issue(0, 17'h00011, 16'h0, 2'b11);
                    wait_done();
                end

                // R8 request while busy is ignored
                issue(0, 17'h00011, 16'h0, 2'b11);
                chk(req_ready == 0, "R8", "ready low while busy", req_ready, 0);
                req_valid = 1; req_write = 1; req_addr = 17'h00020;
                req_wdata = 16'hBEEF; req_mask = 2'b11;
                @(negedge clk);
                req_valid = 0;
                wait_done();
                issue(0, 17'h00020, 16'h0, 2'b11);
                wait_done();

                // mixed traffic
                for (int i = 0; i < 12; i++)
                    issue(1, 17'(i * 37 + 100), 16'(i * 16'h1357) ^ 16'h0F0F, 2'(i % 3 + 1));
                for (int i = 0; i < 12; i++) begin
                    issue(0, 17'(i * 37 + 100), 16'h0, 2'b11);
                    issue(0, 17'(i * 37 + 100), 16'h0, 2'((i + 1) % 3 + 1));
                end
                wait_done();
                chk(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL R8 watchdog: actual hung expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule